// File: doc/BRIEF.md
# PCI Target Back-End Address Decoder

This block sits on the user side of a PCI target core. When the core flags the start of an access, the block captures the target address and the bus command from the shared bus. It then keeps its own burst address and moves it forward one 32-bit word each time the core reports that a data transfer has finished. The captured command is sorted into a user-read class and a user-write class. The captured start address is compared against one memory window and one I/O window. A select output is raised only when the matching space is enabled by the command-register enable inputs.

When the memory window is selected, write data strobed by the core goes into a 16-word register file. Only the byte lanes whose active-low enables are low are written. Read data is driven combinationally from the word at the current burst address.

A two-state tracker controls the sequencing. `ST_IDLE` is the state after reset, and no access has been seen yet. The transition *capture* leaves it on the first address-valid clock. `ST_DATA` is the state in which an access is open. Its transitions are *recapture* (address-valid again, which starts a new access), *advance* (increment pulse) and *hold* (neither of the two).

Top module: `pci_tgt_decoder`

## Requirements
- R1: On a rising clock edge with `addr_valid` high, `ad_bus` is captured as both the start address and the burst address, and `cmd_be` is captured as the command. `burst_addr` shows the captured address from the next cycle on.
- R2: In `ST_DATA`, a clock edge with `addr_inc` high and `addr_valid` low adds 4 to `burst_addr`. With neither input high, `burst_addr` holds. When both are high, the capture of R1 wins.
- R3: `user_rd_decode` is high while the captured command is 4'b0010, 4'b0110, 4'b1100 or 4'b1110.
- R4: `user_wr_decode` is high while the captured command is 4'b0011, 4'b0111 or 4'b1111. Every other code raises neither decode output.
- R5: The memory window is hit when captured address bits [31:6] equal those of `MEM_BASE` (default 32'h8000_0000) and the command is a memory read or write. `target_select` then rises only if `mem_space_en` is high.
- R6: The I/O window is hit when captured address bits [31:4] equal those of `IO_BASE` (default 32'h0000_1000) and the command is 4'b0010 or 4'b0011. `target_select` then rises only if `io_space_en` is high.
- R7: Reset clears the burst address, the command and the register file, and puts the tracker in `ST_IDLE`. The block stays unselected until the first capture.
- R8: A clock edge with `wr_strobe` high, `addr_valid` low, a memory hit and a write command writes the word at index `burst_addr[5:2]`. Byte lane n (bits 8n+7:8n) is written only when `cmd_be[n]` is 0.
- R9: `cfg_wr_strobe` never changes user storage. It also blocks a `wr_strobe` that is high in the same cycle.
- R10: On a memory hit, `rd_data` equals the stored word at `burst_addr[5:2]` in the same cycle. Otherwise it is zero.
- R11: When `wr_strobe` and `addr_inc` are high on the same edge, the data lands at the address before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_bus | input | 32 | Address in the address phase, write data afterwards |
| cmd_be | input | 4 | Command in the address phase, active-low byte enables afterwards |
| addr_valid | input | 1 | Start of an access; address and command are valid |
| addr_inc | input | 1 | The previous data transfer has completed |
| wr_strobe | input | 1 | Valid user write data on `ad_bus` |
| cfg_wr_strobe | input | 1 | Configuration write in progress |
| mem_space_en | input | 1 | Memory-space enable from the command register |
| io_space_en | input | 1 | I/O-space enable from the command register |
| user_rd_decode | output | 1 | Captured command is a read type |
| user_wr_decode | output | 1 | Captured command is a write type |
| target_select | output | 1 | Access falls inside an enabled window |
| burst_addr | output | 32 | Current burst address |
| rd_data | output | 32 | Read data for the current burst address |

## Verification
A data write and the increment that follows it can fall on the same edge. The register file must take the word index from before the increment, while the burst address moves to the next word. The bench drives `wr_strobe` and `addr_inc` together on consecutive data beats. It then reopens the window with a read access and walks the burst, checking that each word sits at the index it was written to. Address capture and increment can also coincide; the bench raises both and expects the new address rather than the old one plus four.

// File: rtl/pcitd_pkg.sv
package pcitd_pkg;

    localparam logic [3:0] CMD_IO_RD      = 4'b0010;
    localparam logic [3:0] CMD_IO_WR      = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD     = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
    localparam logic [3:0] CMD_MEM_RD_MUL = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LN  = 4'b1110;
    localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic io;
        logic mem;
    } cmd_class_t;

endpackage

// File: rtl/pcitd_addr_track.sv
module pcitd_addr_track
    import pcitd_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 4,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ad_bus,
    input  logic [CW-1:0] cmd_be,
    input  logic          addr_valid,
    input  logic          addr_inc,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] burst_addr,
    output logic [CW-1:0] cmd_q,
    output logic          active
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    trk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (addr_valid) state_d = ST_DATA;
            ST_DATA: state_d = ST_DATA;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_addr <= '0;
            burst_addr <= '0;
            cmd_q      <= '0;
        end else if (addr_valid) begin
            start_addr <= ad_bus;
            burst_addr <= ad_bus;
            cmd_q      <= cmd_be;
        end else if (addr_inc && state_q == ST_DATA) begin
            burst_addr <= burst_addr + STEP_V;
        end
    end

    always_comb begin
        active = (state_q == ST_DATA);
    end

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> burst_addr == $past(ad_bus)); // R1

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && addr_inc && !addr_valid) |=> burst_addr == $past(burst_addr) + STEP_V); // R2

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && !addr_inc) |=> $stable(burst_addr)); // R2

endmodule

// File: rtl/pcitd_cmd_decode.sv
module pcitd_cmd_decode
    import pcitd_pkg::*;
(
    input  logic [3:0]  cmd,
    input  logic        active,
    output cmd_class_t  cls
);

    always_comb begin
        cls = '0;
        if (active) begin
            case (cmd)
                CMD_IO_RD:      begin cls.rd = 1'b1; cls.io  = 1'b1; end
                CMD_IO_WR:      begin cls.wr = 1'b1; cls.io  = 1'b1; end
                CMD_MEM_RD,
                CMD_MEM_RD_MUL,
                CMD_MEM_RD_LN:  begin cls.rd = 1'b1; cls.mem = 1'b1; end
                CMD_MEM_WR,
                CMD_MEM_WR_INV: begin cls.wr = 1'b1; cls.mem = 1'b1; end
                default:        cls = '0;
            endcase
        end
    end

endmodule

// File: rtl/pcitd_bar_match.sv
module pcitd_bar_match
    import pcitd_pkg::*;
#(
    parameter int          AW          = 32,
    parameter logic [31:0] MEM_BASE    = 32'h8000_0000,
    parameter int          MEM_WIN_LOG2 = 6,
    parameter logic [31:0] IO_BASE     = 32'h0000_1000,
    parameter int          IO_WIN_LOG2 = 4
) (
    input  logic [AW-1:0] start_addr,
    input  cmd_class_t    cls,
    input  logic          mem_en,
    input  logic          io_en,
    output logic          mem_hit,
    output logic          io_hit,
    output logic          select
);

    localparam logic [AW-1:0] MEM_MASK = ~((AW'(1) << MEM_WIN_LOG2) - AW'(1));
    localparam logic [AW-1:0] IO_MASK  = ~((AW'(1) << IO_WIN_LOG2) - AW'(1));
    localparam logic [AW-1:0] MEM_TAG  = AW'(MEM_BASE) & MEM_MASK;
    localparam logic [AW-1:0] IO_TAG   = AW'(IO_BASE) & IO_MASK;

    logic mem_win, io_win;

    always_comb begin
        mem_win = (start_addr & MEM_MASK) == MEM_TAG;
        io_win  = (start_addr & IO_MASK)  == IO_TAG;
        mem_hit = mem_win && cls.mem && mem_en;
        io_hit  = io_win  && cls.io  && io_en;
        select  = mem_hit || io_hit;
    end

endmodule

// File: rtl/pcitd_regfile.sv
module pcitd_regfile #(
    parameter int DW    = 32,
    parameter int WORDS = 16,
    localparam int IW    = $clog2(WORDS),
    localparam int LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IW-1:0]    idx,
    input  logic [LANES-1:0] be_n,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] lane_q [WORDS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int w = 0; w < WORDS; w++) lane_q[w] <= '0;
            end else if (we && !be_n[l]) begin
                lane_q[idx] <= wdata[8*l +: 8];
            end
        end

        assign rdata[8*l +: 8] = lane_q[idx];
    end

endmodule

// File: rtl/pci_tgt_decoder.sv
module pci_tgt_decoder
    import pcitd_pkg::*;
#(
    parameter int          DW           = 32,
    parameter int          WORDS        = 16,
    parameter logic [31:0] MEM_BASE     = 32'h8000_0000,
    parameter int          MEM_WIN_LOG2 = 6,
    parameter logic [31:0] IO_BASE      = 32'h0000_1000,
    parameter int          IO_WIN_LOG2  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ad_bus,
    input  logic [3:0]    cmd_be,
    input  logic          addr_valid,
    input  logic          addr_inc,
    input  logic          wr_strobe,
    input  logic          cfg_wr_strobe,
    input  logic          mem_space_en,
    input  logic          io_space_en,
    output logic          user_rd_decode,
    output logic          user_wr_decode,
    output logic          target_select,
    output logic [DW-1:0] burst_addr,
    output logic [DW-1:0] rd_data
);

    localparam int IW   = $clog2(WORDS);
    localparam int STEP = DW / 8;
    localparam int LSB  = $clog2(STEP);

    logic [DW-1:0] start_addr;
    logic [3:0]    cmd_q;
    logic          active;
    cmd_class_t    cls;
    logic          mem_hit, io_hit;
    logic          rf_we;
    logic [DW-1:0] rf_rdata;

    pcitd_addr_track #(.AW(DW), .CW(4), .STEP(STEP)) u_track (
        .clk(clk), .rst_n(rst_n), .ad_bus(ad_bus), .cmd_be(cmd_be),
        .addr_valid(addr_valid), .addr_inc(addr_inc),
        .start_addr(start_addr), .burst_addr(burst_addr),
        .cmd_q(cmd_q), .active(active)
    );

    pcitd_cmd_decode u_dec (.cmd(cmd_q), .active(active), .cls(cls));

    pcitd_bar_match #(
        .AW(DW), .MEM_BASE(MEM_BASE), .MEM_WIN_LOG2(MEM_WIN_LOG2),
        .IO_BASE(IO_BASE), .IO_WIN_LOG2(IO_WIN_LOG2)
    ) u_bar (
        .start_addr(start_addr), .cls(cls), .mem_en(mem_space_en),
        .io_en(io_space_en), .mem_hit(mem_hit), .io_hit(io_hit),
        .select(target_select)
    );

    always_comb begin
        rf_we = wr_strobe && !cfg_wr_strobe && !addr_valid && mem_hit && cls.wr;
    end

    pcitd_regfile #(.DW(DW), .WORDS(WORDS)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we),
        .idx(burst_addr[LSB +: IW]), .be_n(cmd_be[STEP-1:0]),
        .wdata(ad_bus), .rdata(rf_rdata)
    );

    always_comb begin
        user_rd_decode = cls.rd;
        user_wr_decode = cls.wr;
        rd_data        = mem_hit ? rf_rdata : '0;
    end

    AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(user_rd_decode && user_wr_decode)); // R4

    AST_SEL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        target_select |-> (mem_space_en || io_space_en)); // R5

    AST_IO_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (io_hit && !mem_hit) |-> rd_data == '0); // R10

    AST_CFG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_strobe && !addr_valid && !addr_inc) |=>
        ($stable(rd_data) || !$stable(mem_space_en) || !$stable(io_space_en))); // R9

endmodule

// File: tb/pci_tgt_decoder_test.sv
module pci_tgt_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_bus = '0;
    logic [3:0]  cmd_be = '0;
    logic        addr_valid = 1'b0, addr_inc = 1'b0, wr_strobe = 1'b0;
    logic        cfg_wr_strobe = 1'b0, mem_space_en = 1'b0, io_space_en = 1'b0;
    logic        user_rd_decode, user_wr_decode, target_select;
    logic [31:0] burst_addr, rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pci_tgt_decoder uut (
        .clk(clk), .rst_n(rst_n), .ad_bus(ad_bus), .cmd_be(cmd_be),
        .addr_valid(addr_valid), .addr_inc(addr_inc), .wr_strobe(wr_strobe),
        .cfg_wr_strobe(cfg_wr_strobe), .mem_space_en(mem_space_en),
        .io_space_en(io_space_en), .user_rd_decode(user_rd_decode),
        .user_wr_decode(user_wr_decode), .target_select(target_select),
        .burst_addr(burst_addr), .rd_data(rd_data)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic addr_phase(logic [31:0] a, logic [3:0] c);
        @(negedge clk);
        ad_bus = a; cmd_be = c; addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0; cmd_be = 4'hF; ad_bus = '0;
    endtask

    task automatic data_beat(logic [31:0] d, logic [3:0] be, logic wr, logic cfg, logic inc);
        ad_bus = d; cmd_be = be; wr_strobe = wr; cfg_wr_strobe = cfg; addr_inc = inc;
        @(negedge clk);
        wr_strobe = 1'b0; cfg_wr_strobe = 1'b0; addr_inc = 1'b0; cmd_be = 4'hF; ad_bus = '0;
    endtask

    task automatic t_reset();
        chk("R7 burst_addr", burst_addr, 32'h0);
        chk("R7 select", {31'b0, target_select}, 32'h0);
        chk("R7 decodes", {30'b0, user_rd_decode, user_wr_decode}, 32'h0);
        chk("R7 rd_data", rd_data, 32'h0);
    endtask

    task automatic t_decode();
        for (int c = 0; c < 16; c++) begin
            logic er, ew;
            er = (c == 2) || (c == 6) || (c == 12) || (c == 14);
            ew = (c == 3) || (c == 7) || (c == 15);
            addr_phase(32'h0000_2000, 4'(c));
            chk($sformatf("R3 rd cmd %0d", c), {31'b0, user_rd_decode}, {31'b0, er});
            chk($sformatf("R4 wr cmd %0d", c), {31'b0, user_wr_decode}, {31'b0, ew});
        end
    endtask

    task automatic t_write_read();
        mem_space_en = 1'b1; io_space_en = 1'b1;
        addr_phase(32'h8000_0008, 4'b0111);
        chk("R1 capture", burst_addr, 32'h8000_0008);
        chk("R5 mem select", {31'b0, target_select}, 32'h1);
        data_beat(32'hAABB_CCDD, 4'b0000, 1'b1, 1'b0, 1'b1);
        chk("R2 inc", burst_addr, 32'h8000_000C);
        chk("R11 word3 empty", rd_data, 32'h0);
        data_beat(32'h1122_3344, 4'b1010, 1'b1, 1'b0, 1'b1);
        chk("R11 burst advance", burst_addr, 32'h8000_0010);
        addr_phase(32'h8000_0008, 4'b0110);
        chk("R10 word2", rd_data, 32'hAABB_CCDD);
        data_beat(32'h0, 4'hF, 1'b0, 1'b0, 1'b1);
        chk("R8 word3 byte mask", rd_data, 32'h0022_0044);
        data_beat(32'h0, 4'hF, 1'b0, 1'b0, 1'b0);
        chk("R2 hold", burst_addr, 32'h8000_000C);
    endtask

    task automatic t_capture_wins();
        addr_phase(32'h8000_0020, 4'b0110);
        @(negedge clk);
        ad_bus = 32'h8000_0030; cmd_be = 4'b0110; addr_valid = 1'b1; addr_inc = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0; addr_inc = 1'b0;
        chk("R2 capture beats inc", burst_addr, 32'h8000_0030);
    endtask

    task automatic t_gating();
        mem_space_en = 1'b0; io_space_en = 1'b1;
        addr_phase(32'h8000_0008, 4'b0110);
        chk("R5 mem disabled", {31'b0, target_select}, 32'h0);
        chk("R10 unselected zero", rd_data, 32'h0);
        mem_space_en = 1'b1; io_space_en = 1'b0;
        addr_phase(32'h0000_1004, 4'b0010);
        chk("R6 io disabled", {31'b0, target_select}, 32'h0);
        io_space_en = 1'b1;
        @(negedge clk);
        chk("R6 io enabled", {31'b0, target_select}, 32'h1);
        chk("R10 io no data", rd_data, 32'h0);
        addr_phase(32'h0000_1014, 4'b0010);
        chk("R6 outside io window", {31'b0, target_select}, 32'h0);
        addr_phase(32'h8000_0008, 4'b0010);
        chk("R6 io cmd in mem window", {31'b0, target_select}, 32'h0);
        addr_phase(32'h0000_1004, 4'b0110);
        chk("R5 mem cmd in io window", {31'b0, target_select}, 32'h0);
        addr_phase(32'h8000_0040, 4'b0110);
        chk("R5 outside mem window", {31'b0, target_select}, 32'h0);
    endtask

    task automatic t_cfg_block();
        mem_space_en = 1'b1;
        addr_phase(32'h8000_0014, 4'b0111);
        data_beat(32'hDEAD_BEEF, 4'b0000, 1'b0, 1'b1, 1'b0);
        chk("R9 cfg only", rd_data, 32'h0);
        data_beat(32'hDEAD_BEEF, 4'b0000, 1'b1, 1'b1, 1'b0);
        chk("R9 cfg blocks user write", rd_data, 32'h0);
        data_beat(32'h5555_AAAA, 4'b1100, 1'b1, 1'b0, 1'b0);
        chk("R8 low lanes only", rd_data, 32'h0000_AAAA);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_write_read();
        t_capture_wins();
        t_gating();
        t_cfg_block();
        finish_run();
    end

endmodule